// File: doc/BRIEF.md
# Multi-Lane Packet Output Router

The router sits between a packet source and a set of serial output lanes. It takes 48-bit hit packets over a valid/ready handshake and places each accepted packet into the buffer of one lane. Each lane sends its packets on as 8-bit symbols for an 8b/10b encoder that sits after it. A symbol is fetched from a lane only on that lane's own strobe, which marks when the lane's slower serial clock wants a new symbol.

A lane-count input selects how many lanes, from 1 up to 8, take part. The lanes in use are the lowest-numbered ones. Packets go to these lanes in rotating order. A lane with nothing to send puts out the comma control symbol as filler.

An almost-full flag tells the source early that the lanes are not keeping up. The ready signal drops only when every lane in use is completely full.

Top module: `pkt_lane_router`

## Requirements
- R1: After reset, every lane output shows the idle symbol 0xBC with its K flag at 1, `pkt_ready` is 1, `almost_full` is 0, and exactly one lane (lane 0) is in use.
- R2: At most one packet is taken per clock, on an edge where `pkt_valid` and `pkt_ready` are both 1. `pkt_ready` is 1 exactly when at least one lane in use has a free slot.
- R3: The number of lanes in use equals `lane_cnt_cfg`, with 0 treated as 1 and any value above 8 treated as 8. Lanes with an index at or above that number never receive a packet.
- R4: Each accepted packet goes to the first lane that is in use and not full, searching upward in index from the lane that took the previous packet and wrapping from lane 7 to lane 0. The first packet after reset goes to lane 0. A full lane is skipped.
- R5: A packet leaves its lane as six symbols with K=0: bits 47:40 first, then 39:32, and so on down to bits 7:0. Each symbol is registered on an edge where that lane's bit of `lane_strobe` is 1 and is held until the lane's next strobe. A packet accepted on the same edge as a strobe to an empty lane is not visible to that strobe.
- R6: A strobe to a lane whose buffer is empty registers the idle symbol 0xBC with K=1.
- R7: Each lane buffer holds four packets. A packet keeps its slot until its sixth symbol has been registered.
- R8: `almost_full` is 1 exactly when some lane in use holds three or more packets. It follows the buffer state after each edge.
- R9: A new lane count takes effect only on an edge at which every lane buffer is empty. On any other edge the count in force is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_data | input | 48 | Hit packet |
| pkt_valid | input | 1 | Packet present |
| pkt_ready | output | 1 | A lane in use has a free slot |
| lane_cnt_cfg | input | 4 | Requested number of lanes in use |
| lane_strobe | input | 8 | Per-lane request for the next symbol |
| lane_sym | output | 64 | Per-lane symbol, lane i on bits 8i+7:8i |
| lane_is_k | output | 8 | Per-lane control-symbol flag |
| almost_full | output | 1 | Back-pressure warning to the source |

## Verification
`pkt_ready` and `almost_full` depend only on the buffer state before the next edge. The bench compares them shortly after each falling edge, once the new inputs are driven. An accepted packet is assigned to its lane on the rising edge that accepts it. Its first symbol can appear at the earliest one rising edge later, on the lane's next strobe; each later symbol follows on a later strobe. The lane outputs are compared 1 ns after every rising edge. At that point the bench's queue model has applied the same edge: it pops symbols on strobes before it pushes new packets. This ordering makes the same-edge accept-and-strobe case predict an idle symbol. A lane-count change is applied in the model only on an edge where its queues were all empty beforehand.

// File: rtl/pkt_router_pkg.sv
package pkt_router_pkg;

    localparam int SYM_BITS = 8;
    localparam logic [SYM_BITS-1:0] IDLE_SYM = 8'hBC;

    typedef struct packed {
        logic                is_k;
        logic [SYM_BITS-1:0] data;
    } sym_t;

    localparam sym_t IDLE_WORD = '{is_k: 1'b1, data: IDLE_SYM};

    function automatic int unsigned clamp_lanes(int unsigned raw, int unsigned max_lanes);
        if (raw == 0)
            return 1;
        if (raw > max_lanes)
            return max_lanes;
        return raw;
    endfunction

endpackage

// File: rtl/lane_unit.sv
module lane_unit
    import pkt_router_pkg::*;
#(
    parameter int PKT_SYMS = 6,
    parameter int DEPTH    = 4,
    localparam int PKT_W   = PKT_SYMS * SYM_BITS,
    localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int IDXW    = (PKT_SYMS > 1) ? $clog2(PKT_SYMS) : 1,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [PKT_W-1:0] push_pkt,
    input  logic             strobe,
    output sym_t             sym_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             near_full_o
);

    logic [PKT_W-1:0] slot_mem [DEPTH];
    logic [AW-1:0]    wr_p, rd_p;
    logic [CNT_W-1:0] occ;
    logic [IDXW-1:0]  sidx;
    logic             has_pkt, last_sym, pop;

    assign has_pkt  = (occ != '0);
    assign last_sym = (sidx == IDXW'(PKT_SYMS - 1));
    assign pop      = strobe && has_pkt && last_sym;

    assign empty_o     = !has_pkt;
    assign full_o      = (occ == CNT_W'(DEPTH));
    assign near_full_o = (occ >= CNT_W'(DEPTH - 1));

    always_ff @(posedge clk) begin
        if (push)
            slot_mem[wr_p] <= push_pkt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_p  <= '0;
            rd_p  <= '0;
            occ   <= '0;
            sidx  <= '0;
            sym_o <= IDLE_WORD;
        end else begin
            if (push)
                wr_p <= (wr_p == AW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
            if (strobe) begin
                if (has_pkt) begin
                    sym_o.is_k <= 1'b0;
                    sym_o.data <= slot_mem[rd_p][(PKT_SYMS - 1 - int'(sidx)) * SYM_BITS +: SYM_BITS];
                    sidx       <= last_sym ? '0 : sidx + 1'b1;
                    if (last_sym)
                        rd_p <= (rd_p == AW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
                end else begin
                    sym_o <= IDLE_WORD;
                end
            end
            occ <= occ + CNT_W'(push) - CNT_W'(pop);
        end
    end

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N   = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [IW-1:0] last,
    input  logic [N-1:0]  elig,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] gidx,
    output logic          any
);

    always_comb begin
        int idx;
        grant = '0;
        gidx  = last;
        any   = 1'b0;
        for (int k = 1; k <= N; k++) begin
            idx = (int'(last) + k) % N;
            if (!any && elig[idx]) begin
                any        = 1'b1;
                grant[idx] = 1'b1;
                gidx       = IW'(idx);
            end
        end
    end

endmodule

// File: rtl/pkt_lane_router.sv
module pkt_lane_router
    import pkt_router_pkg::*;
#(
    parameter int NUM_LANES = 8,
    parameter int PKT_SYMS  = 6,
    parameter int DEPTH     = 4,
    localparam int PKT_W    = PKT_SYMS * SYM_BITS,
    localparam int CW       = $clog2(NUM_LANES + 1),
    localparam int IW       = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [PKT_W-1:0]              pkt_data,
    input  logic                          pkt_valid,
    output logic                          pkt_ready,
    input  logic [CW-1:0]                 lane_cnt_cfg,
    input  logic [NUM_LANES-1:0]          lane_strobe,
    output logic [NUM_LANES*SYM_BITS-1:0] lane_sym,
    output logic [NUM_LANES-1:0]          lane_is_k,
    output logic                          almost_full
);

    logic [CW-1:0]        act_n;
    logic [IW-1:0]        last_lane, pick_idx;
    logic [NUM_LANES-1:0] active, elig, grant, push_vec;
    logic [NUM_LANES-1:0] empty_vec, full_vec, near_vec;
    logic                 pick_any, accept, all_idle;
    sym_t                 lane_out [NUM_LANES];

    assign all_idle    = &empty_vec;
    assign elig        = active & ~full_vec;
    assign pkt_ready   = |elig;
    assign accept      = pkt_valid && pick_any;
    assign push_vec    = accept ? grant : '0;
    assign almost_full = |(active & near_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_n     <= CW'(1);
            last_lane <= IW'(NUM_LANES - 1);
        end else begin
            if (all_idle)
                act_n <= CW'(clamp_lanes(int'(lane_cnt_cfg), NUM_LANES));
            if (accept)
                last_lane <= pick_idx;
        end
    end

    rr_pick #(.N(NUM_LANES)) u_pick (
        .last  (last_lane),
        .elig  (elig),
        .grant (grant),
        .gidx  (pick_idx),
        .any   (pick_any)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign active[i] = (act_n > CW'(i));

        lane_unit #(.PKT_SYMS(PKT_SYMS), .DEPTH(DEPTH)) u_lane (
            .clk         (clk),
            .rst         (rst),
            .push        (push_vec[i]),
            .push_pkt    (pkt_data),
            .strobe      (lane_strobe[i]),
            .sym_o       (lane_out[i]),
            .empty_o     (empty_vec[i]),
            .full_o      (full_vec[i]),
            .near_full_o (near_vec[i])
        );

        assign lane_sym[i*SYM_BITS +: SYM_BITS] = lane_out[i].data;
        assign lane_is_k[i]                     = lane_out[i].is_k;
    end

endmodule

// File: rtl/pkt_lane_router_chk.sv
module pkt_lane_router_chk #(
    parameter int NUM_LANES = 8,
    localparam int CW       = $clog2(NUM_LANES + 1)
) (
    input logic                   clk,
    input logic                   rst,
    input logic [CW-1:0]          act_n,
    input logic                   all_idle,
    input logic [NUM_LANES-1:0]   push_vec,
    input logic [NUM_LANES-1:0]   full_vec,
    input logic [NUM_LANES-1:0]   empty_vec,
    input logic [NUM_LANES-1:0]   lane_strobe,
    input logic [NUM_LANES*8-1:0] lane_sym,
    input logic [NUM_LANES-1:0]   lane_is_k
);

    // R2: never more than one lane loaded per clock
    a_r2_one_push: assert property (@(posedge clk) disable iff (rst)
        $countones(push_vec) <= 1);

    // R7: a full lane is never written
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push_vec & full_vec) == '0);

    // R3: lanes outside the count in force receive nothing
    a_r3_inactive_quiet: assert property (@(posedge clk) disable iff (rst)
        (push_vec >> act_n) == '0);

    // R3: the count in force stays within range
    a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
        act_n >= CW'(1) && act_n <= CW'(NUM_LANES));

    // R9: count is held unless every lane was empty
    a_r9_hold_busy: assert property (@(posedge clk) disable iff (rst)
        !all_idle |=> $stable(act_n));

    // R6: strobe to an empty lane 0 gives the idle comma
    a_r6_idle_fill: assert property (@(posedge clk) disable iff (rst)
        lane_strobe[0] && empty_vec[0] |=> lane_is_k[0] && lane_sym[7:0] == 8'hBC);

    // R5: strobe to a loaded lane 0 gives a data symbol
    a_r5_data_sym: assert property (@(posedge clk) disable iff (rst)
        lane_strobe[0] && !empty_vec[0] |=> !lane_is_k[0]);

endmodule

bind pkt_lane_router pkt_lane_router_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .act_n       (act_n),
    .all_idle    (all_idle),
    .push_vec    (push_vec),
    .full_vec    (full_vec),
    .empty_vec   (empty_vec),
    .lane_strobe (lane_strobe),
    .lane_sym    (lane_sym),
    .lane_is_k   (lane_is_k)
);

// File: tb/pkt_lane_router_bench.sv
`timescale 1ns/1ps
module pkt_lane_router_bench;

    localparam int NL = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [47:0]   pkt_data = '0;
    logic          pkt_valid = 1'b0;
    logic          pkt_ready;
    logic [3:0]    lane_cnt_cfg = 4'd1;
    logic [NL-1:0] lane_strobe = '0;
    logic [NL*8-1:0] lane_sym;
    logic [NL-1:0] lane_is_k;
    logic          almost_full;

    int checks = 0;
    int errors = 0;

    // scoreboard state
    logic [7:0] exp_q [NL][$];
    logic [7:0] exp_sym [NL];
    logic       exp_k [NL];
    int         m_act = 1;
    int         m_ptr = NL - 1;
    int         pkt_n = 0;

    always #2.5 clk = ~clk;

    pkt_lane_router u_pkt_lane_router (
        .clk          (clk),
        .rst          (rst),
        .pkt_data     (pkt_data),
        .pkt_valid    (pkt_valid),
        .pkt_ready    (pkt_ready),
        .lane_cnt_cfg (lane_cnt_cfg),
        .lane_strobe  (lane_strobe),
        .lane_sym     (lane_sym),
        .lane_is_k    (lane_is_k),
        .almost_full  (almost_full)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int mcnt(int l);
        return (exp_q[l].size() + 5) / 6;
    endfunction

    function automatic bit m_elig(int l);
        return (l < m_act) && (mcnt(l) < 4);
    endfunction

    function automatic int clampc(int raw);
        if (raw == 0) return 1;
        if (raw > NL) return NL;
        return raw;
    endfunction

    function automatic logic [47:0] mkpkt(int n);
        return {8'(n), 8'hA1, 8'(n * 3), 8'h5C, 8'(n + 7), 8'hE4};
    endfunction

    // one clock: drive, check handshake, model the edge, compare lanes
    task automatic step(input bit valid, input logic [NL-1:0] strb, input string tag);
        bit m_ready, m_af, acc, idle_all;
        int g;
        logic [47:0] d;
        @(negedge clk);
        d           = mkpkt(pkt_n);
        pkt_valid   = valid;
        pkt_data    = d;
        lane_strobe = strb;
        #1;
        m_ready = 0; m_af = 0; g = -1;
        for (int l = 0; l < NL; l++) begin
            if (m_elig(l)) m_ready = 1;
            if (l < m_act && mcnt(l) >= 3) m_af = 1;
        end
        for (int k = 1; k <= NL; k++) begin
            int l = (m_ptr + k) % NL;
            if (g < 0 && m_elig(l)) g = l;
        end
        check(pkt_ready == m_ready, "R2", "pkt_ready", 64'(pkt_ready), 64'(m_ready));
        check(almost_full == m_af, "R8", "almost_full", 64'(almost_full), 64'(m_af));
        @(posedge clk);
        acc = valid && m_ready;
        idle_all = 1;
        for (int l = 0; l < NL; l++)
            if (exp_q[l].size() != 0) idle_all = 0;
        for (int l = 0; l < NL; l++) begin
            if (strb[l]) begin
                if (exp_q[l].size() != 0) begin
                    exp_sym[l] = exp_q[l].pop_front();
                    exp_k[l]   = 1'b0;
                end else begin
                    exp_sym[l] = 8'hBC;
                    exp_k[l]   = 1'b1;
                end
            end
        end
        if (acc) begin
            for (int s = 5; s >= 0; s--)
                exp_q[g].push_back(d[s*8 +: 8]);
            m_ptr = g;
            pkt_n++;
        end
        if (idle_all) m_act = clampc(int'(lane_cnt_cfg));
        #1;
        for (int l = 0; l < NL; l++) begin
            check(lane_sym[l*8 +: 8] == exp_sym[l] && lane_is_k[l] == exp_k[l], tag,
                  $sformatf("lane %0d symbol", l),
                  64'({lane_is_k[l], lane_sym[l*8 +: 8]}), 64'({exp_k[l], exp_sym[l]}));
        end
    endtask

    task automatic drain(input string tag);
        for (int c = 0; c < 200; c++) begin
            bit busy = 0;
            for (int l = 0; l < NL; l++) if (exp_q[l].size() != 0) busy = 1;
            if (!busy) break;
            step(1'b0, '1, tag);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int l = 0; l < NL; l++) begin exp_sym[l] = 8'hBC; exp_k[l] = 1'b1; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(pkt_ready == 1'b1, "R1", "ready after reset", 64'(pkt_ready), 64'd1);
        check(almost_full == 1'b0, "R1", "almost_full after reset", 64'(almost_full), 64'd0);
        for (int l = 0; l < NL; l++)
            check(lane_sym[l*8 +: 8] == 8'hBC && lane_is_k[l], "R1", "idle after reset",
                  64'({lane_is_k[l], lane_sym[l*8 +: 8]}), 64'h1BC);
        step(1'b0, '1, "R6");

        // R5 R4: single lane, bytes MSB first; same-edge strobe sees idle
        lane_cnt_cfg = 4'd1;
        step(1'b1, 8'h01, "R5");
        step(1'b1, 8'h00, "R4");
        for (int i = 0; i < 14; i++) step(1'b0, (i % 2 == 0) ? 8'h01 : 8'h00, "R5");
        drain("R6");

        // R3 R4: three lanes, round robin with no strobes
        lane_cnt_cfg = 4'd3;
        step(1'b0, '0, "R3");
        for (int i = 0; i < 6; i++) step(1'b1, '0, "R4");
        drain("R3");

        // R7 R8 R4: two lanes filled to full, skip a full lane
        lane_cnt_cfg = 4'd2;
        step(1'b0, '0, "R3");
        for (int i = 0; i < 7; i++) step(1'b1, '0, "R8");
        for (int i = 0; i < 6; i++) step(1'b0, 8'h02, "R7");
        step(1'b1, '0, "R4");
        step(1'b1, '0, "R4");
        step(1'b1, '0, "R7");
        for (int i = 0; i < 6; i++) step(1'b0, 8'h01, "R7");
        step(1'b1, '0, "R4");

        // R9: change requested while busy is held
        lane_cnt_cfg = 4'd8;
        for (int i = 0; i < 3; i++) step(1'b1, 8'h03, "R9");
        drain("R9");
        for (int i = 0; i < 10; i++) step(1'b1, '0, "R3");
        drain("R3");

        // R3: out-of-range counts clamp
        lane_cnt_cfg = 4'd0;
        step(1'b0, '0, "R3");
        for (int i = 0; i < 3; i++) step(1'b1, '0, "R3");
        drain("R3");
        lane_cnt_cfg = 4'd12;
        step(1'b0, '0, "R3");
        for (int i = 0; i < 10; i++) step(1'b1, 8'h55, "R2");
        drain("R5");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule